// File: doc/BRIEF.md
# Processor Exception Entry Unit

This unit performs the entry step of exception and interrupt handling for a simple 32-bit RISC core that has branch delay slots. Each cycle it looks at a synchronous exception request, which carries an index, and at two interrupt lines: one for external interrupts and one for the tick timer. It gates the interrupt lines with the enable bits of the current status word. When it accepts an event, the next clock edge does four things together. It stores a corrected return address, and it stores a copy of the untouched status word. It produces the rewritten supervisor status word and drives the new program counter at the event's vector.

The surrounding core loads the new PC and the new status word when the one-cycle entry pulse is high. It also clears its own delay-slot flag when the clear pulse is high, and it treats the flush pulse as a request to invalidate address translation, because the privilege level has changed. An index with no vector is not taken. It produces only an error pulse and leaves all saved state as it was.

Top module: `exc_entry`

## Requirements
- R1: On an accepted entry outside a delay slot, and with any index other than 0xC, `epc_o` becomes `pc_i` one cycle after the request.
- R2: When `dslot_i` is high on an accepted entry, the saved return address is `pc_i - 4` (modulo 2^32). Bit 13 (delay-slot exception) of `sr_o` is set, and `dslot_clr_o` pulses for one cycle.
- R3: For index 0xC (system call), 4 is added to the saved return address after the delay-slot correction. A system call in a delay slot therefore saves `pc_i`.
- R4: On an accepted entry, `esr_o` captures `sr_i` exactly as it was presented, before any rewrite.
- R5: On an accepted entry, `sr_o` equals `sr_i` with bit 0 (supervisor) set, and with bits 1 (tick enable), 2 (interrupt enable), 5 (data translation enable) and 6 (instruction translation enable) cleared. All other bits are kept, apart from bit 13 as described in R2.
- R6: On an accepted entry, `vector_o` is the accepted index shifted left by 8 bits.
- R7: A synchronous request with index 0, or with an index of 16 or more, pulses `bad_vec_o` for one cycle. In that case there is no entry pulse, no flush pulse and no delay-slot clear, and `epc_o`, `esr_o`, `sr_o` and `vector_o` keep their values.
- R8: The external interrupt is taken only while `sr_i` bit 2 is set. The tick interrupt is taken only while `sr_i` bit 1 is set. An interrupt that is not enabled changes no output.
- R9: When both interrupts are pending and enabled, the tick interrupt is taken with index 0x5 (vector 0x500). The external interrupt alone uses index 0x8 (vector 0x800).
- R10: A synchronous request in the same cycle as pending, enabled interrupts is the one taken, using its own index.
- R11: Every accepted entry raises `entry_o` and `tlb_flush_o` for exactly that one cycle. A cycle with no request leaves both low.
- R12: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | PC of the instruction being interrupted |
| sr_i | input | 16 | Current status word |
| dslot_i | input | 1 | Instruction is in a delay slot |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_idx_i | input | 5 | Index of the synchronous exception |
| irq_ext_i | input | 1 | External interrupt pending |
| irq_tick_i | input | 1 | Tick-timer interrupt pending |
| entry_o | output | 1 | One-cycle pulse: an entry was committed |
| vector_o | output | 32 | New program counter |
| epc_o | output | 32 | Saved return address |
| esr_o | output | 16 | Saved status word |
| sr_o | output | 16 | Rewritten status word for the handler |
| dslot_clr_o | output | 1 | One-cycle pulse: clear the delay-slot flag |
| tlb_flush_o | output | 1 | One-cycle translation-flush request |
| bad_vec_o | output | 1 | One-cycle pulse: the index has no vector |

## Verification
Two arbitration points can meet in one cycle. The first is both interrupt lines pending with both enables set. The second is a synchronous request arriving while those interrupts are pending. The bench provokes each case by driving all the competing inputs on the same falling edge, and also provokes a variant where only one enable is set. It then judges the outcome from the vector and saved address that appear after the next rising edge. The delay-slot and system-call corrections also fall together on one entry, and the bench checks that case through the saved address equalling the PC.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SYNC = 2'd1,
    SRC_TICK = 2'd2,
    SRC_EXT  = 2'd3
  } exc_src_e;
endpackage

// File: rtl/exc_select.sv
module exc_select
  import exc_entry_pkg::*;
#(
  parameter int IDXW     = 5,
  parameter int TICK_IDX = 5,
  parameter int EXT_IDX  = 8
) (
  input  logic            req_i,
  input  logic [IDXW-1:0] req_idx_i,
  input  logic            ext_i,
  input  logic            tick_i,
  input  logic            ext_en_i,
  input  logic            tick_en_i,
  output exc_src_e        src_o,
  output logic [IDXW-1:0] idx_o
);
  localparam logic [IDXW-1:0] TICK_CODE = IDXW'(TICK_IDX);
  localparam logic [IDXW-1:0] EXT_CODE  = IDXW'(EXT_IDX);

  always_comb begin
    src_o = SRC_NONE;
    idx_o = '0;
    if (req_i) begin
      src_o = SRC_SYNC;
      idx_o = req_idx_i;
    end else if (tick_i && tick_en_i) begin
      src_o = SRC_TICK;
      idx_o = TICK_CODE;
    end else if (ext_i && ext_en_i) begin
      src_o = SRC_EXT;
      idx_o = EXT_CODE;
    end
  end
endmodule

// File: rtl/exc_epc_adj.sv
module exc_epc_adj #(
  parameter int PCW  = 32,
  parameter int STEP = 4
) (
  input  logic [PCW-1:0] pc_i,
  input  logic           dslot_i,
  input  logic           syscall_i,
  output logic [PCW-1:0] epc_o
);
  localparam logic [PCW-1:0] STEP_V = PCW'(STEP);

  logic [PCW-1:0] back;

  always_comb begin
    back  = dslot_i ? (pc_i - STEP_V) : pc_i;
    epc_o = syscall_i ? (back + STEP_V) : back;
  end
endmodule

// File: rtl/exc_sr_entry.sv
module exc_sr_entry #(
  parameter int SRW     = 16,
  parameter int BIT_SM  = 0,
  parameter int BIT_TEE = 1,
  parameter int BIT_IEE = 2,
  parameter int BIT_DME = 5,
  parameter int BIT_IME = 6,
  parameter int BIT_DSX = 13
) (
  input  logic [SRW-1:0] sr_i,
  input  logic           dslot_i,
  output logic [SRW-1:0] sr_o
);
  for (genvar b = 0; b < SRW; b++) begin : g_bit
    if (b == BIT_SM) begin : g_set
      assign sr_o[b] = 1'b1;
    end else if (b == BIT_TEE || b == BIT_IEE || b == BIT_DME || b == BIT_IME) begin : g_clr
      assign sr_o[b] = 1'b0;
    end else if (b == BIT_DSX) begin : g_dsx
      assign sr_o[b] = sr_i[b] | dslot_i;
    end else begin : g_keep
      assign sr_o[b] = sr_i[b];
    end
  end
endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_entry_pkg::*;
#(
  parameter int PCW         = 32,
  parameter int SRW         = 16,
  parameter int IDXW        = 5,
  parameter int NUM_EXC     = 16,
  parameter int VEC_SHIFT   = 8,
  parameter int SYSCALL_IDX = 12,
  parameter int TICK_IDX    = 5,
  parameter int EXT_IDX     = 8,
  parameter int BIT_SM      = 0,
  parameter int BIT_TEE     = 1,
  parameter int BIT_IEE     = 2,
  parameter int BIT_DME     = 5,
  parameter int BIT_IME     = 6,
  parameter int BIT_DSX     = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PCW-1:0]  pc_i,
  input  logic [SRW-1:0]  sr_i,
  input  logic            dslot_i,
  input  logic            exc_req_i,
  input  logic [IDXW-1:0] exc_idx_i,
  input  logic            irq_ext_i,
  input  logic            irq_tick_i,
  output logic            entry_o,
  output logic [PCW-1:0]  vector_o,
  output logic [PCW-1:0]  epc_o,
  output logic [SRW-1:0]  esr_o,
  output logic [SRW-1:0]  sr_o,
  output logic            dslot_clr_o,
  output logic            tlb_flush_o,
  output logic            bad_vec_o
);
  localparam logic [IDXW-1:0] SYSCALL_CODE = IDXW'(SYSCALL_IDX);
  localparam logic [PCW-1:0]  TICK_VEC     = PCW'(TICK_IDX) << VEC_SHIFT;

  exc_src_e        src;
  logic [IDXW-1:0] idx;
  logic            taken, idx_ok, commit;
  logic [PCW-1:0]  epc_calc, vec_calc;
  logic [SRW-1:0]  sr_calc;

  exc_select #(.IDXW(IDXW), .TICK_IDX(TICK_IDX), .EXT_IDX(EXT_IDX)) u_sel (
    .req_i     (exc_req_i),
    .req_idx_i (exc_idx_i),
    .ext_i     (irq_ext_i),
    .tick_i    (irq_tick_i),
    .ext_en_i  (sr_i[BIT_IEE]),
    .tick_en_i (sr_i[BIT_TEE]),
    .src_o     (src),
    .idx_o     (idx)
  );

  exc_epc_adj #(.PCW(PCW), .STEP(4)) u_epc (
    .pc_i      (pc_i),
    .dslot_i   (dslot_i),
    .syscall_i (idx == SYSCALL_CODE),
    .epc_o     (epc_calc)
  );

  exc_sr_entry #(
    .SRW(SRW), .BIT_SM(BIT_SM), .BIT_TEE(BIT_TEE), .BIT_IEE(BIT_IEE),
    .BIT_DME(BIT_DME), .BIT_IME(BIT_IME), .BIT_DSX(BIT_DSX)
  ) u_sr (
    .sr_i    (sr_i),
    .dslot_i (dslot_i),
    .sr_o    (sr_calc)
  );

  always_comb begin
    taken    = (src != SRC_NONE);
    idx_ok   = (idx != '0) && (32'(idx) < NUM_EXC);
    commit   = taken && idx_ok;
    vec_calc = PCW'(idx) << VEC_SHIFT;
  end

  logic            entry_d, flush_d, bad_d, dsclr_d;
  logic [PCW-1:0]  epc_d, vec_d;
  logic [SRW-1:0]  esr_d, sr_d;

  always_comb begin
    entry_d = commit;
    flush_d = commit;
    dsclr_d = commit && dslot_i;
    bad_d   = taken && !idx_ok;
    epc_d   = epc_o;
    vec_d   = vector_o;
    esr_d   = esr_o;
    sr_d    = sr_o;
    if (commit) begin
      epc_d = epc_calc;
      vec_d = vec_calc;
      esr_d = sr_i;
      sr_d  = sr_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_o     <= 1'b0;
      tlb_flush_o <= 1'b0;
      dslot_clr_o <= 1'b0;
      bad_vec_o   <= 1'b0;
      epc_o       <= '0;
      vector_o    <= '0;
      esr_o       <= '0;
      sr_o        <= '0;
    end else begin
      entry_o     <= entry_d;
      tlb_flush_o <= flush_d;
      dslot_clr_o <= dsclr_d;
      bad_vec_o   <= bad_d;
      if (commit) begin
        epc_o    <= epc_d;
        vector_o <= vec_d;
        esr_o    <= esr_d;
        sr_o     <= sr_d;
      end
    end
  end

  assert_esr_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> esr_o == $past(sr_i));
  assert_sr_rewrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> (sr_o[BIT_SM] && !sr_o[BIT_IEE] && !sr_o[BIT_TEE]
                 && !sr_o[BIT_DME] && !sr_o[BIT_IME]));
  assert_vec_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> vector_o[VEC_SHIFT-1:0] == '0);
  assert_bad_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_vec_o |-> (!entry_o && !tlb_flush_o && $stable(epc_o) && $stable(vector_o)));
  assert_tick_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && !$past(exc_req_i) && $past(irq_tick_i && sr_i[BIT_TEE])) |-> vector_o == TICK_VEC);
  assert_flush_with_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tlb_flush_o) |-> entry_o);
  assert_dsx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dslot_clr_o |-> (entry_o && sr_o[BIT_DSX]));
endmodule

// File: tb/tb_exc_entry.sv
module tb_exc_entry;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic [31:0] pc_i;
  logic [15:0] sr_i;
  logic        dslot_i, exc_req_i, irq_ext_i, irq_tick_i;
  logic [4:0]  exc_idx_i;
  logic        entry_o, dslot_clr_o, tlb_flush_o, bad_vec_o;
  logic [31:0] vector_o, epc_o;
  logic [15:0] esr_o, sr_o;

  exc_entry dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .sr_i(sr_i), .dslot_i(dslot_i),
    .exc_req_i(exc_req_i), .exc_idx_i(exc_idx_i), .irq_ext_i(irq_ext_i),
    .irq_tick_i(irq_tick_i), .entry_o(entry_o), .vector_o(vector_o),
    .epc_o(epc_o), .esr_o(esr_o), .sr_o(sr_o), .dslot_clr_o(dslot_clr_o),
    .tlb_flush_o(tlb_flush_o), .bad_vec_o(bad_vec_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct packed {
    logic        req;
    logic [4:0]  idx;
    logic        ext;
    logic        tick;
    logic        dslot;
    logic [15:0] sr;
    logic [31:0] pc;
    logic        ent;
    logic        bad;
    logic [31:0] vec;
    logic [31:0] epc;
  } row_t;

  localparam int NROWS = 15;
  localparam row_t TABLE [NROWS] = '{
    '{1'b1, 5'd3,  1'b0, 1'b0, 1'b0, 16'h0067, 32'h0000_1000, 1'b1, 1'b0, 32'h300, 32'h0000_1000},
    '{1'b1, 5'd3,  1'b0, 1'b0, 1'b1, 16'h8006, 32'h0000_2000, 1'b1, 1'b0, 32'h300, 32'h0000_1FFC},
    '{1'b1, 5'd12, 1'b0, 1'b0, 1'b0, 16'h0000, 32'h0000_3000, 1'b1, 1'b0, 32'hC00, 32'h0000_3004},
    '{1'b1, 5'd12, 1'b0, 1'b0, 1'b1, 16'h0100, 32'h0000_4000, 1'b1, 1'b0, 32'hC00, 32'h0000_4000},
    '{1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 16'h0004, 32'h0000_5000, 1'b1, 1'b0, 32'h800, 32'h0000_5000},
    '{1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 16'h0000, 32'h0000_5100, 1'b0, 1'b0, 32'h800, 32'h0000_5000},
    '{1'b0, 5'd0,  1'b0, 1'b1, 1'b0, 16'h0002, 32'h0000_6000, 1'b1, 1'b0, 32'h500, 32'h0000_6000},
    '{1'b0, 5'd0,  1'b0, 1'b1, 1'b0, 16'h0004, 32'h0000_6100, 1'b0, 1'b0, 32'h500, 32'h0000_6000},
    '{1'b0, 5'd0,  1'b1, 1'b1, 1'b0, 16'h0006, 32'h0000_7000, 1'b1, 1'b0, 32'h500, 32'h0000_7000},
    '{1'b0, 5'd0,  1'b1, 1'b1, 1'b0, 16'h0004, 32'h0000_7100, 1'b1, 1'b0, 32'h800, 32'h0000_7100},
    '{1'b1, 5'd2,  1'b1, 1'b1, 1'b0, 16'h0006, 32'h0000_8000, 1'b1, 1'b0, 32'h200, 32'h0000_8000},
    '{1'b1, 5'd0,  1'b1, 1'b0, 1'b1, 16'h0004, 32'h0000_9000, 1'b0, 1'b1, 32'h200, 32'h0000_8000},
    '{1'b1, 5'd16, 1'b0, 1'b0, 1'b0, 16'h0000, 32'h0000_9100, 1'b0, 1'b1, 32'h200, 32'h0000_8000},
    '{1'b1, 5'd15, 1'b0, 1'b0, 1'b0, 16'h0020, 32'h0000_A000, 1'b1, 1'b0, 32'hF00, 32'h0000_A000},
    '{1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 16'h0006, 32'h0000_B000, 1'b0, 1'b0, 32'hF00, 32'h0000_A000}
  };

  function automatic string row_tag(int i);
    case (i)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4, 5, 6, 7: return "R8";
      8, 9: return "R9";
      10: return "R10";
      11, 12: return "R7";
      13: return "R6";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [15:0] entry_sr(logic [15:0] s, logic ds);
    return (s & ~16'h0066) | 16'h0001 | (ds ? 16'h2000 : 16'h0000);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    exc_req_i = 0; exc_idx_i = '0; irq_ext_i = 0; irq_tick_i = 0;
    dslot_i = 0; sr_i = '0; pc_i = '0;
  endtask

  logic [15:0] exp_esr, exp_sr;

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "entry", {31'd0, entry_o}, 32'd0);
    check("R12", "flush", {31'd0, tlb_flush_o}, 32'd0);
    check("R12", "bad", {31'd0, bad_vec_o}, 32'd0);
    check("R12", "epc", epc_o, 32'd0);
    check("R12", "vector", vector_o, 32'd0);
    check("R12", "sr", {16'd0, sr_o}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    exp_esr = '0;
    exp_sr  = '0;
    for (int i = 0; i < NROWS; i++) begin
      exc_req_i  = TABLE[i].req;
      exc_idx_i  = TABLE[i].idx;
      irq_ext_i  = TABLE[i].ext;
      irq_tick_i = TABLE[i].tick;
      dslot_i    = TABLE[i].dslot;
      sr_i       = TABLE[i].sr;
      pc_i       = TABLE[i].pc;
      if (TABLE[i].ent) begin
        exp_esr = TABLE[i].sr;
        exp_sr  = entry_sr(TABLE[i].sr, TABLE[i].dslot);
      end
      @(negedge clk);
      check(row_tag(i), "entry", {31'd0, entry_o}, {31'd0, TABLE[i].ent});
      check("R11", "flush", {31'd0, tlb_flush_o}, {31'd0, TABLE[i].ent});
      check(row_tag(i), "bad", {31'd0, bad_vec_o}, {31'd0, TABLE[i].bad});
      check(row_tag(i), "vector", vector_o, TABLE[i].vec);
      check(row_tag(i), "epc", epc_o, TABLE[i].epc);
      check("R4", "esr", {16'd0, esr_o}, {16'd0, exp_esr});
      check("R5", "sr", {16'd0, sr_o}, {16'd0, exp_sr});
      check("R2", "dslot_clr", {31'd0, dslot_clr_o},
            {31'd0, TABLE[i].ent && TABLE[i].dslot});
    end

    // R2: delay slot at address zero wraps
    exc_req_i = 1; exc_idx_i = 5'd7; dslot_i = 1; pc_i = 32'h0; sr_i = 16'h0;
    @(negedge clk);
    check("R2", "epc wrap", epc_o, 32'hFFFF_FFFC);
    check("R2", "sr dsx", {16'd0, sr_o}, 32'h0000_2001);

    // R11: back-to-back entries keep flush high each cycle
    dslot_i = 0; pc_i = 32'h100; exc_idx_i = 5'd1;
    @(negedge clk);
    check("R11", "flush b2b", {31'd0, tlb_flush_o}, 32'd1);
    check("R6", "vector b2b", vector_o, 32'h100);
    idle_inputs();
    @(negedge clk);
    check("R11", "flush drop", {31'd0, tlb_flush_o}, 32'd0);

    // R12: reset mid-run clears held state
    rst_n = 0;
    @(negedge clk);
    check("R12", "epc after reset", epc_o, 32'd0);
    check("R12", "vector after reset", vector_o, 32'd0);
    rst_n = 1;
    @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule